// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the sync and framing strobes for a parallel RGB panel from timing words written through a small register port. It drives a horizontal sync, a vertical sync, a data-enable, a flag for an inner active window, a select that picks the border colour, and the current pixel column and line. Horizontal events are placed with a line pixel counter. Vertical events are placed with one frame-linear pixel counter, so every vertical threshold is a pixel-clock count from the first pixel of the frame, not a line number.

Software writes the timing words into staging registers. The live copy that drives the counters and comparators is reloaded only at a frame boundary, or at any time while generation is stopped. A running frame therefore never mixes two configurations. The enable word takes effect at once. An optional inner window lies inside the display area. Display pixels outside this window are marked for the border colour.

Top module: `disp_timing_gen`

## Requirements
- R1: While rst_ni is low, every output is 0. This includes x_o and y_o, and both syncs, because polarity resets to active-high.
- R2: While the enable word (address 11, bit 0) is 0, de_o, win_o, border_o, x_o and y_o are 0. hsync_o and vsync_o rest at their inactive level, which equals their polarity bit.
- R3: While running, x_o steps by one per clock and wraps to 0 after line period − 1. The line period is bits 31:16 of address 0. y_o steps by one at each line wrap and returns to 0 after the frame period − 1 pixel. The frame period is the 32-bit word at address 1.
- R4: The raw hsync is active while the line position, delayed by the skew at address 9 bits 15:0 (modulo the line period), is below the pulse width in bits 15:0 of address 0.
- R5: The raw vsync is active while the frame pixel index (y × line period + x) is below the pixel count at address 2.
- R6: de_o is 1 when x lies between the first pixel (address 3 bits 15:0) and the last pixel (address 3 bits 31:16), inclusive. The frame pixel index must also lie between the vertical start (address 4) and the vertical end (address 5), inclusive.
- R7: The inner window is on only when bit 31 of address 6 and bit 31 of address 7 are both set. Its bounds are x from bits 15:0 to bits 30:16 of address 6, and frame index from address 7 bits 30:0 to address 8 bits 30:0. When the window is on, win_o = de_o AND inside, and border_o = de_o AND NOT inside. When it is off, win_o = de_o and border_o = 0.
- R8: Bit 0 of address 10 inverts hsync_o and bit 1 inverts vsync_o.
- R9: Timing words written while running take effect at the first pixel of the next frame. The rest of the current frame keeps the old values.
- R10: Writing 1 to the enable word starts a frame at pixel 0, line 0. The first running output shows x = 0, y = 0, and the next shows x = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Display data enable |
| win_o | output | 1 | Pixel lies in the active window |
| border_o | output | 1 | Pixel takes the border colour |
| x_o | output | 16 | Current pixel column |
| y_o | output | 16 | Current line |

## Verification
The bench keeps the default 32-bit frame counter and 16-bit line fields, and programs two small panels: a 20×10 raster and a 24×12 raster. Frames of a few hundred pixels let every pixel of several whole frames be compared against an arithmetic model. These sweeps cover sync edges, porch boundaries, the skew wrap at line start, and both edges of a centred window. The second panel is loaded in mid-frame, which exposes the frame-boundary handover. A stop and restart exercises the idle levels under inverted polarity.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LINE_W  = 16;
  localparam int unsigned FRAME_W = 32;
  localparam int unsigned ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LINE   = 4'd0,
    A_FRAME  = 4'd1,
    A_VPULSE = 4'd2,
    A_HDISP  = 4'd3,
    A_VSTART = 4'd4,
    A_VEND   = 4'd5,
    A_WINH   = 4'd6,
    A_WINVS  = 4'd7,
    A_WINVE  = 4'd8,
    A_SKEW   = 4'd9,
    A_POL    = 4'd10,
    A_ENABLE = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic [LINE_W-1:0]  line_len;
    logic [LINE_W-1:0]  hpw;
    logic [FRAME_W-1:0] frame_len;
    logic [FRAME_W-1:0] vpw;
    logic [LINE_W-1:0]  h_first;
    logic [LINE_W-1:0]  h_last;
    logic [FRAME_W-1:0] v_start;
    logic [FRAME_W-1:0] v_end;
    logic               win_h_en;
    logic               win_v_en;
    logic [LINE_W-1:0]  win_first;
    logic [LINE_W-1:0]  win_last;
    logic [FRAME_W-1:0] win_vs;
    logic [FRAME_W-1:0] win_ve;
    logic [LINE_W-1:0]  skew;
    logic [1:0]         pol;
  } timing_t;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output timing_t           live_o,
  output logic              en_o
);
  localparam int unsigned HI_W = LINE_W - 1;

  timing_t stage_q, live_q;
  logic    en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      en_q    <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_LINE: begin
          stage_q.line_len <= wr_data_i[31:16];
          stage_q.hpw      <= wr_data_i[15:0];
        end
        A_FRAME:  stage_q.frame_len <= wr_data_i;
        A_VPULSE: stage_q.vpw       <= wr_data_i;
        A_HDISP: begin
          stage_q.h_last  <= wr_data_i[31:16];
          stage_q.h_first <= wr_data_i[15:0];
        end
        A_VSTART: stage_q.v_start <= wr_data_i;
        A_VEND:   stage_q.v_end   <= wr_data_i;
        A_WINH: begin
          stage_q.win_h_en  <= wr_data_i[31];
          stage_q.win_last  <= {1'b0, wr_data_i[16 +: HI_W]};
          stage_q.win_first <= wr_data_i[15:0];
        end
        A_WINVS: begin
          stage_q.win_v_en <= wr_data_i[31];
          stage_q.win_vs   <= {1'b0, wr_data_i[30:0]};
        end
        A_WINVE:  stage_q.win_ve <= {1'b0, wr_data_i[30:0]};
        A_SKEW:   stage_q.skew   <= wr_data_i[15:0];
        A_POL:    stage_q.pol    <= wr_data_i[1:0];
        A_ENABLE: en_q           <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // live copy only moves at a frame boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      live_q <= '0;
    else if (load_i)  live_q <= stage_q;
  end

  assign live_o = live_q;
  assign en_o   = en_q;
endmodule

// File: rtl/dtg_counters.sv
module dtg_counters
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W = FRAME_W,
  parameter int unsigned POS_W = LINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [POS_W-1:0] line_len_i,
  input  logic [CNT_W-1:0] frame_len_i,
  output logic [CNT_W-1:0] fc_o,
  output logic [POS_W-1:0] lc_o,
  output logic [POS_W-1:0] yc_o,
  output logic             frame_end_o
);
  logic [CNT_W-1:0] fc_q;
  logic [POS_W-1:0] lc_q, yc_q;
  logic             line_end;

  assign frame_end_o = en_i && (fc_q >= frame_len_i - 1'b1);
  assign line_end    = lc_q >= line_len_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fc_q <= '0;
      lc_q <= '0;
      yc_q <= '0;
    end else if (!en_i || frame_end_o) begin
      fc_q <= '0;
      lc_q <= '0;
      yc_q <= '0;
    end else begin
      fc_q <= fc_q + 1'b1;
      if (line_end) begin
        lc_q <= '0;
        yc_q <= yc_q + 1'b1;
      end else begin
        lc_q <= lc_q + 1'b1;
      end
    end
  end

  assign fc_o = fc_q;
  assign lc_o = lc_q;
  assign yc_o = yc_q;
endmodule

// File: rtl/dtg_decode.sv
module dtg_decode
  import dtg_pkg::*;
#(
  parameter int unsigned CNT_W = FRAME_W,
  parameter int unsigned POS_W = LINE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  timing_t          cfg_i,
  input  logic [CNT_W-1:0] fc_i,
  input  logic [POS_W-1:0] lc_i,
  input  logic [POS_W-1:0] yc_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             win_o,
  output logic             border_o,
  output logic [POS_W-1:0] x_o,
  output logic [POS_W-1:0] y_o
);
  logic [POS_W-1:0] hpos;
  logic hs_raw, vs_raw, de_raw, win_on, win_in, win_raw, bord_raw;

  always_comb begin
    // skew delays the pulse, wrapping inside the line
    if (lc_i >= cfg_i.skew) hpos = lc_i - cfg_i.skew;
    else                    hpos = lc_i + cfg_i.line_len - cfg_i.skew;
    hs_raw   = hpos < cfg_i.hpw;
    vs_raw   = fc_i < cfg_i.vpw;
    de_raw   = (lc_i >= cfg_i.h_first) && (lc_i <= cfg_i.h_last) &&
               (fc_i >= cfg_i.v_start) && (fc_i <= cfg_i.v_end);
    win_on   = cfg_i.win_h_en && cfg_i.win_v_en;
    win_in   = (lc_i >= cfg_i.win_first) && (lc_i <= cfg_i.win_last) &&
               (fc_i >= cfg_i.win_vs) && (fc_i <= cfg_i.win_ve);
    win_raw  = de_raw && (!win_on || win_in);
    bord_raw = de_raw && win_on && !win_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hsync_o  <= 1'b0;
      vsync_o  <= 1'b0;
      de_o     <= 1'b0;
      win_o    <= 1'b0;
      border_o <= 1'b0;
      x_o      <= '0;
      y_o      <= '0;
    end else if (!en_i) begin
      hsync_o  <= cfg_i.pol[0];
      vsync_o  <= cfg_i.pol[1];
      de_o     <= 1'b0;
      win_o    <= 1'b0;
      border_o <= 1'b0;
      x_o      <= '0;
      y_o      <= '0;
    end else begin
      hsync_o  <= hs_raw ^ cfg_i.pol[0];
      vsync_o  <= vs_raw ^ cfg_i.pol[1];
      de_o     <= de_raw;
      win_o    <= win_raw;
      border_o <= bord_raw;
      x_o      <= lc_i;
      y_o      <= yc_i;
    end
  end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              win_o,
  output logic              border_o,
  output logic [LINE_W-1:0] x_o,
  output logic [LINE_W-1:0] y_o
);
  timing_t            live;
  logic               en_q;
  logic               frame_end;
  logic [FRAME_W-1:0] fc;
  logic [LINE_W-1:0]  lc, yc;

  dtg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .load_i    (!en_q || frame_end),
    .live_o    (live),
    .en_o      (en_q)
  );

  dtg_counters #(.CNT_W(FRAME_W), .POS_W(LINE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .line_len_i  (live.line_len),
    .frame_len_i (live.frame_len),
    .fc_o        (fc),
    .lc_o        (lc),
    .yc_o        (yc),
    .frame_end_o (frame_end)
  );

  dtg_decode #(.CNT_W(FRAME_W), .POS_W(LINE_W)) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .cfg_i    (live),
    .fc_i     (fc),
    .lc_i     (lc),
    .yc_i     (yc),
    .hsync_o  (hsync_o),
    .vsync_o  (vsync_o),
    .de_o     (de_o),
    .win_o    (win_o),
    .border_o (border_o),
    .x_o      (x_o),
    .y_o      (y_o)
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              de_i,
  input logic              win_i,
  input logic              border_i,
  input logic [LINE_W-1:0] x_i,
  input logic [LINE_W-1:0] y_i
);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!de_i && !win_i && !border_i && x_i == '0 && y_i == '0));

  a_r3_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (x_i == '0 || x_i == $past(x_i) + 1'b1));

  a_r3_y_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> (y_i == '0 || y_i == $past(y_i) || y_i == $past(y_i) + 1'b1));

  a_r7_win_in_de: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_i |-> de_i);

  a_r7_border_in_de: assert property (@(posedge clk_i) disable iff (!rst_ni)
    border_i |-> (de_i && !win_i));
endmodule

bind disp_timing_gen dtg_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (en_q),
  .de_i     (de_o),
  .win_i    (win_o),
  .border_i (border_o),
  .x_i      (x_o),
  .y_i      (y_o)
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, win, border;
  logic [15:0] x, y;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // expected live config (c_) and pending staged config (p_)
  int c_L, c_hpw, c_fr, c_vpw, c_hf, c_hl, c_vs, c_ve, c_wen, c_wf, c_wl, c_wvs, c_wve, c_skew, c_pol;
  int p_L, p_hpw, p_fr, p_vpw, p_hf, p_hl, p_vs, p_ve, p_wen, p_wf, p_wl, p_wvs, p_wve, p_skew, p_pol;
  bit pend = 0;
  bit have_prev = 0;
  int prev_x, prev_y;

  disp_timing_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .win_o(win), .border_o(border), .x_o(x), .y_o(y)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic adopt();
    c_L = p_L; c_hpw = p_hpw; c_fr = p_fr; c_vpw = p_vpw; c_hf = p_hf; c_hl = p_hl;
    c_vs = p_vs; c_ve = p_ve; c_wen = p_wen; c_wf = p_wf; c_wl = p_wl;
    c_wvs = p_wvs; c_wve = p_wve; c_skew = p_skew; c_pol = p_pol;
  endtask

  task automatic program_pending();
    logic [31:0] d;
    wr(0, (32'(p_L) << 16) | 32'(p_hpw));
    wr(1, 32'(p_fr));
    wr(2, 32'(p_vpw));
    wr(3, (32'(p_hl) << 16) | 32'(p_hf));
    wr(4, 32'(p_vs));
    wr(5, 32'(p_ve));
    d = (32'(p_wl) << 16) | 32'(p_wf); d[31] = p_wen[0];
    wr(6, d);
    d = 32'(p_wvs); d[31] = p_wen[0];
    wr(7, d);
    wr(8, 32'(p_wve));
    wr(9, 32'(p_skew));
    wr(10, 32'(p_pol));
  endtask

  // panel A: 20 x 10 raster, window off, plain polarity
  task automatic set_a();
    p_L = 20; p_hpw = 3; p_fr = 200; p_vpw = 40; p_hf = 7; p_hl = 16;
    p_vs = 80; p_ve = 179; p_wen = 0; p_wf = 9; p_wl = 14; p_wvs = 100; p_wve = 159;
    p_skew = 0; p_pol = 0;
  endtask

  // panel B: 24 x 12 raster, centred window on, skew 5, both syncs inverted
  task automatic set_b();
    p_L = 24; p_hpw = 2; p_fr = 288; p_vpw = 24; p_hf = 7; p_hl = 18;
    p_vs = 101; p_ve = 244; p_wen = 1; p_wf = 9; p_wl = 16; p_wvs = 125; p_wve = 220;
    p_skew = 5; p_pol = 3;
  endtask

  task automatic model_check();
    int xi, yi, f, hpos, nl;
    bit e_hs, e_vs, e_de, e_in, e_win, e_bd;
    xi = int'(x); yi = int'(y);
    if (have_prev) begin
      int ex, ey;
      nl = c_fr / c_L;
      if (prev_x == c_L - 1) begin
        ex = 0; ey = (prev_y == nl - 1) ? 0 : prev_y + 1;
      end else begin
        ex = prev_x + 1; ey = prev_y;
      end
      chk(xi == ex, "R3", "x step", xi, ex);
      chk(yi == ey, "R3", "y step", yi, ey);
    end
    if (pend && xi == 0 && yi == 0) begin
      adopt();
      pend = 0;
    end
    f = yi * c_L + xi;
    hpos = (xi >= c_skew) ? xi - c_skew : xi + c_L - c_skew;
    e_hs = (hpos < c_hpw) ^ c_pol[0];
    e_vs = (f < c_vpw) ^ c_pol[1];
    e_de = (xi >= c_hf) && (xi <= c_hl) && (f >= c_vs) && (f <= c_ve);
    e_in = (xi >= c_wf) && (xi <= c_wl) && (f >= c_wvs) && (f <= c_wve);
    e_win = e_de && (c_wen == 0 || e_in);
    e_bd = e_de && (c_wen != 0) && !e_in;
    chk(hsync == e_hs, pend ? "R9" : "R4", "hsync", int'(hsync), int'(e_hs));
    chk(vsync == e_vs, pend ? "R9" : "R5", "vsync", int'(vsync), int'(e_vs));
    chk(de == e_de, pend ? "R9" : "R6", "de", int'(de), int'(e_de));
    chk(win == e_win, pend ? "R9" : "R7", "win", int'(win), int'(e_win));
    chk(border == e_bd, pend ? "R9" : "R7", "border", int'(border), int'(e_bd));
    prev_x = xi; prev_y = yi; have_prev = 1;
  endtask

  task automatic run_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_check();
    end
  endtask

  task automatic start_and_check_r10();
    wr(11, 32'd1);
    have_prev = 0;
    @(negedge clk);
    chk(x == 16'd0, "R10", "first x", int'(x), 0);
    chk(y == 16'd0, "R10", "first y", int'(y), 0);
    model_check();
    @(negedge clk);
    chk(x == 16'd1, "R10", "second x", int'(x), 1);
    model_check();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk(hsync == 0 && vsync == 0, "R1", "syncs in reset", int'({hsync, vsync}), 0);
    chk(de == 0 && win == 0 && border == 0, "R1", "flags in reset", int'({de, win, border}), 0);
    chk(x == 0 && y == 0, "R1", "position in reset", int'(x) + int'(y), 0);
    rst_ni = 1'b1;

    // configure A while stopped, check idle (R2)
    set_a();
    program_pending();
    adopt();
    repeat (3) @(negedge clk);
    chk(de == 0 && win == 0 && border == 0, "R2", "idle flags", int'({de, win, border}), 0);
    chk(hsync == 0 && vsync == 0, "R2", "idle syncs plain", int'({hsync, vsync}), 0);

    start_and_check_r10();
    run_cycles(2 * 200);

    // reprogram B mid-frame (R9)
    while (int'(y) != 3) @(negedge clk);
    set_b();
    program_pending();
    pend = 1;
    have_prev = 0;
    run_cycles(200 + 3 * 288);
    chk(pend == 0, "R9", "new config reached a frame start", int'(pend), 0);

    // stop: idle under inverted polarity (R2, R8)
    wr(11, 32'd0);
    @(negedge clk);
    chk(hsync == 1 && vsync == 1, "R8", "inverted idle syncs", int'({hsync, vsync}), 3);
    chk(de == 0 && border == 0 && win == 0, "R2", "stopped flags", int'({de, win, border}), 0);
    chk(x == 0 && y == 0, "R2", "stopped position", int'(x) + int'(y), 0);

    start_and_check_r10();
    run_cycles(2 * 288);

    finish_run();
  end
endmodule